// File: doc/BRIEF.md
# Vertical-Crosswise Column Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. All the crosswise bit products are formed at once. The products a[i]·b[j] are grouped by output column k = i + j, and each column is summed into a small multi-bit count. Every column count is produced in parallel, and no column depends on another.

A carry-resolution chain then walks the columns from least to most significant. Each column count is added to the carry that left the column below it. The low bit of that total is the product bit for the column, and the remaining bits move up as the next carry. The carry left over after the top column becomes the most significant product bit.

The datapath is purely combinational. A parameter can add one output register with a synchronous active-low reset. The block is meant to be dropped into a larger arithmetic path, for example as a mantissa multiplier. Signed operands are not handled.

Top module: `vx_column_mult`

## Requirements
- R1: For every pair of unsigned operands, `product` equals `a_op * b_op` computed at full 2N-bit width, with no bit lost.
- R2: The count for column k never exceeds the number of index pairs with i + j = k, which is min(k, 2N-2-k) + 1. With every operand bit set, every column is full and the product is (2^N-1)^2.
- R3: Product bit 0 equals a_op[0] AND b_op[0].
- R4: Product bit 2N-1 is the carry left after the top column. It is 1 exactly when the product is at least 2^(2N-1). For example, 63·62 = 3906 sets bit 11 when N = 6.
- R5: With REG_OUT = 1 (the default), `product` shows the result for the operands present at the previous rising edge of `clk`, and holds it until the next edge. With REG_OUT = 0, `product` follows the operands combinationally.
- R6: With REG_OUT = 1, `rst_n` low at a rising edge clears `product` to zero, whatever the operands are.
- R7: The output width is 2N. With the default N = 6, the largest product, 3969, appears exactly on the 12-bit output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| a_op | input | N | Unsigned multiplicand |
| b_op | input | N | Unsigned multiplier |
| product | output | 2N | Full unsigned product |

## Verification
In the default registered build, each result is due one clock edge after its operands are applied.

Operands are driven on the falling edge, and the expected product is pushed into a scoreboard at that moment. A monitor pops each entry 5 ns after the following rising edge, so it compares exactly the value captured from those operands. Just after each new drive, and before the next rising edge, the driver also confirms that the output still holds the previous result. This checks that the output neither moves early nor loses its value.

// File: rtl/vx_mul_pkg.sv
// Package: width helpers shared by the column multiplier modules.
// Assumes operand width n >= 2.
package vx_mul_pkg;

    // Bits needed to hold a column count of up to n ones.
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

    // Bits needed for a column count plus its incoming carry (always below 2n).
    function automatic int tot_w(input int n);
        return $clog2(2 * n);
    endfunction

endpackage

// File: rtl/vx_term_gen.sv
// Module: vx_term_gen
// Forms every crosswise bit product and files it under its output column.
// Column k gets N slots; slot i holds a[i]&b[k-i] when that index is valid,
// otherwise a constant zero. Purely combinational, all columns in parallel.
module vx_term_gen #(
    parameter int N = 6
) (
    input  logic [N-1:0]           a_op,
    input  logic [N-1:0]           b_op,
    output logic [(2*N-1)*N-1:0]   terms_flat
);
    localparam int COLS = 2 * N - 1;

    for (genvar k = 0; k < COLS; k++) begin : g_col
        for (genvar i = 0; i < N; i++) begin : g_slot
            if ((k - i) >= 0 && (k - i) < N) begin : g_live
                // One crosswise bit product for column k.
                assign terms_flat[k*N + i] = a_op[i] & b_op[k-i];
            end else begin : g_dead
                // Index pair out of range: slot is empty.
                assign terms_flat[k*N + i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vx_col_count.sv
// Module: vx_col_count
// Compresses the N single-bit terms of one column into a binary count.
// The adder chain is left to be mapped onto a carry-save compressor tree.
// Assumes at most N terms, so the count fits in cnt_w(N) bits.
module vx_col_count #(
    parameter int N  = 6,
    parameter int CW = vx_mul_pkg::cnt_w(N)
) (
    input  logic [N-1:0]  terms,
    output logic [CW-1:0] count
);
    // Sum the ones present in this column.
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + CW'(terms[i]);
        end
        count = acc;
    end
endmodule

// File: rtl/vx_carry_ripple.sv
// Module: vx_carry_ripple
// Resolves the column counts from least to most significant column.
// Each total is the column count plus the incoming carry; its low bit is the
// product bit and the rest carries up. The final carry is the top product bit.
// Assumes every count is at most N, so each carry stays below N.
module vx_carry_ripple #(
    parameter int N  = 6,
    parameter int CW = vx_mul_pkg::cnt_w(N),
    parameter int TW = vx_mul_pkg::tot_w(N)
) (
    input  logic [(2*N-1)*CW-1:0] col_cnt_flat,
    output logic [2*N-1:0]        prod_c
);
    localparam int COLS = 2 * N - 1;
    localparam int KW   = TW - 1;

    // Walk the columns, passing the multi-bit carry upward.
    always_comb begin
        logic [KW-1:0] carry;
        logic [TW-1:0] tot;
        carry  = '0;
        tot    = '0;
        prod_c = '0;
        for (int k = 0; k < COLS; k++) begin
            tot       = TW'(col_cnt_flat[k*CW +: CW]) + TW'(carry);
            prod_c[k] = tot[0];
            carry     = tot[TW-1:1];
        end
        prod_c[2*N-1] = carry[0];
    end
endmodule

// File: rtl/vx_column_mult.sv
// Module: vx_column_mult (top)
// Unsigned N x N multiplier built from per-column counts and a multi-bit
// carry chain. REG_OUT=1 adds one output register cleared by synchronous
// active-low reset; REG_OUT=0 leaves the path combinational.
// Assumes N >= 2.
module vx_column_mult #(
    parameter int N       = 6,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a_op,
    input  logic [N-1:0]   b_op,
    output logic [2*N-1:0] product
);
    localparam int COLS = 2 * N - 1;
    localparam int CW   = vx_mul_pkg::cnt_w(N);

    logic [COLS*N-1:0]  terms_flat;
    logic [COLS*CW-1:0] col_cnt_flat;
    logic [2*N-1:0]     prod_c;

    vx_term_gen #(.N(N)) u_terms (
        .a_op       (a_op),
        .b_op       (b_op),
        .terms_flat (terms_flat)
    );

    for (genvar k = 0; k < COLS; k++) begin : g_count
        vx_col_count #(.N(N), .CW(CW)) u_count (
            .terms (terms_flat[k*N +: N]),
            .count (col_cnt_flat[k*CW +: CW])
        );
    end

    vx_carry_ripple #(.N(N), .CW(CW)) u_ripple (
        .col_cnt_flat (col_cnt_flat),
        .prod_c       (prod_c)
    );

    if (REG_OUT) begin : g_reg
        // Capture the resolved product; clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) product <= '0;
            else        product <= prod_c;
        end
    end else begin : g_comb
        // Combinational output.
        assign product = prod_c;
    end
endmodule

// File: rtl/vx_column_mult_chk.sv
// Module: vx_column_mult_chk
// Property checker for vx_column_mult, attached by the bind below.
module vx_column_mult_chk #(
    parameter int N       = 6,
    parameter bit REG_OUT = 1'b1,
    parameter int CW      = vx_mul_pkg::cnt_w(N)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N-1:0]           a_op,
    input logic [N-1:0]           b_op,
    input logic [2*N-1:0]         product,
    input logic [(2*N-1)*CW-1:0]  col_cnt_flat
);
    localparam int PW   = 2 * N;
    localparam int COLS = 2 * N - 1;

    if (REG_OUT) begin : g_reg
        a_r1_product_matches: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> product == PW'($past(a_op)) * PW'($past(b_op)));

        a_r3_bit0: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> product[0] == ($past(a_op[0]) & $past(b_op[0])));

        a_r4_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> product[PW-1] ==
                ((PW'($past(a_op)) * PW'($past(b_op))) >= (PW'(1) << (PW-1))));

        a_r6_reset_clears: assert property (@(posedge clk)
            !rst_n |=> product == '0);
    end else begin : g_comb
        a_r1_product_matches: assert property (@(posedge clk) disable iff (!rst_n)
            product == PW'(a_op) * PW'(b_op));

        a_r3_bit0: assert property (@(posedge clk) disable iff (!rst_n)
            product[0] == (a_op[0] & b_op[0]));
    end

    for (genvar k = 0; k < COLS; k++) begin : g_bound
        localparam int TK = (k < N) ? k + 1 : 2 * N - 1 - k;
        a_r2_column_bound: assert property (@(posedge clk) disable iff (!rst_n)
            int'(col_cnt_flat[k*CW +: CW]) <= TK);
    end
endmodule

bind vx_column_mult vx_column_mult_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .a_op         (a_op),
    .b_op         (b_op),
    .product      (product),
    .col_cnt_flat (col_cnt_flat)
);

// File: tb/vx_column_mult_bench.sv
// Scoreboard bench for vx_column_mult (N=6, registered output, 50 MHz).
module vx_column_mult_bench;
    localparam int N  = 6;
    localparam int PW = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  a_op;
    logic [N-1:0]  b_op;
    logic [PW-1:0] product;

    typedef struct {
        logic [PW-1:0] exp;
        string         tag;
    } item_t;

    item_t         sb[$];
    int            n_cmp = 0;
    int            n_bad = 0;
    logic [PW-1:0] last_exp = '0;

    always #10 clk = ~clk;

    vx_column_mult #(.N(N), .REG_OUT(1'b1)) u_vx_column_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_op    (a_op),
        .b_op    (b_op),
        .product (product)
    );

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Driver: apply operands, push expectation, confirm the output has not moved yet (R5).
    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
        item_t it;
        @(negedge clk);
        a_op = a;
        b_op = b;
        it.exp = PW'(a) * PW'(b);
        it.tag = tag;
        sb.push_back(it);
        #1;
        check("R5 hold before edge", product, last_exp);
        last_exp = it.exp;
    endtask

    // Monitor: one result per rising edge, sampled 5 ns after it.
    initial begin
        forever begin
            item_t it;
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check(it.tag, product, it.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a_op  = '1;
        b_op  = '1;
        repeat (3) @(negedge clk);
        check("R6 reset clears", product, '0);
        a_op = '0;
        b_op = '0;
        rst_n = 1'b1;
        last_exp = '0;

        // Directed corner cases.
        drive(6'd63, 6'd63, "R2 R7 all columns full");
        drive(6'd63, 6'd62, "R4 top bit set");
        drive(6'd32, 6'd32, "R4 top bit clear");
        drive(6'd5,  6'd3,  "R3 bit0 one");
        drive(6'd2,  6'd3,  "R3 bit0 zero");
        drive(6'd0,  6'd63, "R1 zero operand");
        drive(6'd1,  6'd63, "R1 identity");

        // Mid-run reset with live operands.
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        a_op  = 6'd45;
        b_op  = 6'd27;
        @(negedge clk);
        check("R6 reset mid-run", product, '0);
        a_op  = '0;
        b_op  = '0;
        rst_n = 1'b1;
        last_exp = '0;

        // Exhaustive sweep of every operand pair.
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                drive(N'(i), N'(j), "R1 exhaustive");
            end
        end

        repeat (3) @(negedge clk);
        report();
        $finish;
    end
endmodule